// File: doc/BRIEF.md
# Priority-Group Interrupt Controller

This block gathers interrupt events from a set of peripheral modules and turns them into one CPU interrupt request with a vector number. Each module has three event lines: general, receive and transmit. Each line sets its own sticky flag. Each module also holds three enable bits and a 3-bit priority group. All three sources of a module share one vector, and that vector equals the module's index.

The controller registers its arbitration result. It offers the winning request to the CPU only when the request's group is strictly above the level now in service. The CPU answers with an acknowledge, which marks that level active. It later signals end-of-service, which returns to the level that was preempted. Software programs enables and priorities through a small word-addressed register port. It clears flags by writing ones to them. The controller never clears a flag by itself.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A flag sets on the cycle after its event input is high, whatever the state of its enable bit. It reads back in the register word at bits [2:0], in the order bit 0 general, bit 1 receive, bit 2 transmit.
- R2: A flag falls only when software writes a 1 to its bit. An acknowledge leaves every flag unchanged.
- R3: When an event and a software clear of the same flag arrive in the same cycle, the flag is set afterwards.
- R4: A module requests only when some flag is set with its enable bit (register bits [5:3], same order as the flags) also set, and its priority group (register bits [8:6]) is non-zero. Group 0 never requests.
- R5: Among requesting modules, the highest group wins. `irq_vec` is the winner's module index and `irq_level` is its group.
- R6: When requesting modules share the top group, the lowest module index wins.
- R7: `irq_req`, `irq_vec` and `irq_level` follow a change of flags, enables or priorities one clock later. After an event, the request appears on the second rising edge.
- R8: An acknowledge taken while `irq_req` is high makes `cur_level` equal to `irq_level`. The request then drops unless a strictly higher group is pending.
- R9: While a level is in service, only a request from a strictly higher group raises `irq_req`.
- R10: End-of-service removes the highest active level. `cur_level` returns to the preempted level, or to 0.
- R11: A request that lost arbitration stays pending. It is offered again once the serviced flag is cleared and the level is released.
- R12: A register write to address m sets module m's enables and priority, and writes its flag bits one-to-clear. Reading address m returns {priority, enables, flags}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_gen | input | NUM_MOD | General event per module |
| evt_rx | input | NUM_MOD | Receive event per module |
| evt_tx | input | NUM_MOD | Transmit event per module |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Module index addressed |
| reg_wdata | input | 9 | Write word {priority, enables, clear mask} |
| reg_rdata | output | 9 | Read word {priority, enables, flags} |
| cpu_ack | input | 1 | CPU takes the offered interrupt |
| cpu_eoi | input | 1 | CPU ends service of the current level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | AW | Vector number of the winner |
| irq_level | output | 3 | Priority group of the winner |
| cur_level | output | 3 | Level now in service, 0 when idle |

## Verification
The bench builds the block with four modules and the full 3-bit group range. With those values, two modules can tie in one group while a third sits higher, and the same-group and higher-group preemption cases can be set up side by side. Four modules also let group 0, a disabled source and a partly enabled module each sit next to a live request. A nested sequence drives two levels deep into the active-level set and unwinds it. It checks that a same-group loser is offered only after the clear and the release.

// File: rtl/prio_irq_ctrl_pkg.sv
package prio_irq_ctrl_pkg;

    localparam int PRIO_W  = 3;
    localparam int SRC_N   = 3;
    localparam int NUM_LVL = 1 << PRIO_W;

    // register word layout
    localparam int FLG_LSB = 0;
    localparam int EN_LSB  = FLG_LSB + SRC_N;
    localparam int PRI_LSB = EN_LSB + SRC_N;
    localparam int REG_W   = PRI_LSB + PRIO_W;

    typedef enum int {
        SRC_GEN = 0,
        SRC_RX  = 1,
        SRC_TX  = 2
    } src_idx_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [SRC_N-1:0]  en;
        logic [SRC_N-1:0]  flg;
    } src_state_t;

    function automatic logic [PRIO_W-1:0] top_level(input logic [NUM_LVL-1:0] m);
        logic [PRIO_W-1:0] r;
        r = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (m[i]) r = PRIO_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_src_bank.sv
module ipc_src_bank
    import prio_irq_ctrl_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int AW      = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_MOD-1:0]                 evt_gen,
    input  logic [NUM_MOD-1:0]                 evt_rx,
    input  logic [NUM_MOD-1:0]                 evt_tx,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [REG_W-1:0]                   wr_data,
    output logic [NUM_MOD-1:0][SRC_N-1:0]      flg_o,
    output logic [NUM_MOD-1:0][SRC_N-1:0]      en_o,
    output logic [NUM_MOD-1:0][PRIO_W-1:0]     prio_o,
    output logic [NUM_MOD-1:0]                 req_live
);

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_src
        src_state_t       st_d, st_q;
        logic             hit;
        logic [SRC_N-1:0] evt_now;

        always_comb begin
            evt_now          = '0;
            evt_now[SRC_GEN] = evt_gen[g];
            evt_now[SRC_RX]  = evt_rx[g];
            evt_now[SRC_TX]  = evt_tx[g];
            hit              = wr_en && (wr_addr == AW'(g));
            st_d             = st_q;
            if (hit) begin
                st_d.prio = wr_data[PRI_LSB +: PRIO_W];
                st_d.en   = wr_data[EN_LSB  +: SRC_N];
                st_d.flg  = st_q.flg & ~wr_data[FLG_LSB +: SRC_N];
            end
            // an event always wins against a clear in the same cycle
            st_d.flg = st_d.flg | evt_now;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign flg_o[g]    = st_q.flg;
        assign en_o[g]     = st_q.en;
        assign prio_o[g]   = st_q.prio;
        assign req_live[g] = (|(st_q.flg & st_q.en)) && (st_q.prio != '0);
    end

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import prio_irq_ctrl_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int VW      = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_MOD-1:0]             req_live,
    input  logic [NUM_MOD-1:0][PRIO_W-1:0] prio,
    output logic                           win_valid,
    output logic [VW-1:0]                  win_vec,
    output logic [PRIO_W-1:0]              win_prio
);

    typedef struct packed {
        logic              valid;
        logic [VW-1:0]     vec;
        logic [PRIO_W-1:0] prio;
    } arb_t;

    arb_t arb_d, arb_q;

    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        arb_d = '0;
        for (int i = NUM_MOD - 1; i >= 0; i--) begin
            if (req_live[i] && (prio[i] >= arb_d.prio)) begin
                arb_d.valid = 1'b1;
                arb_d.vec   = VW'(i);
                arb_d.prio  = prio[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign win_valid = arb_q.valid;
    assign win_vec   = arb_q.vec;
    assign win_prio  = arb_q.prio;

endmodule

// File: rtl/ipc_level_stack.sv
module ipc_level_stack
    import prio_irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic [PRIO_W-1:0] cur_level
);

    logic [NUM_LVL-1:0] act_d, act_q;
    logic [PRIO_W-1:0]  top_q;

    assign top_q = top_level(act_q);

    // one bit per group: levels in service nest strictly upward
    always_comb begin
        act_d = act_q;
        if (pop && (top_q != '0)) act_d[top_q] = 1'b0;
        if (push && (push_lvl != '0)) act_d[push_lvl] = 1'b1;
        act_d[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign cur_level = top_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_ctrl_pkg::*;
#(
    parameter int NUM_MOD = 4,
    localparam int AW     = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_MOD-1:0]    evt_gen,
    input  logic [NUM_MOD-1:0]    evt_rx,
    input  logic [NUM_MOD-1:0]    evt_tx,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  cpu_ack,
    input  logic                  cpu_eoi,
    output logic                  irq_req,
    output logic [AW-1:0]         irq_vec,
    output logic [PRIO_W-1:0]     irq_level,
    output logic [PRIO_W-1:0]     cur_level
);

    logic [NUM_MOD-1:0][SRC_N-1:0]  flg_w;
    logic [NUM_MOD-1:0][SRC_N-1:0]  en_w;
    logic [NUM_MOD-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_MOD-1:0]             req_live;
    logic [NUM_MOD-1:0][SRC_N-1:0]  evt_all;
    logic                           win_valid;
    logic [AW-1:0]                  win_vec;
    logic [PRIO_W-1:0]              win_prio;
    logic                           take;

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_evt
        assign evt_all[g] = {evt_tx[g], evt_rx[g], evt_gen[g]};
    end

    ipc_src_bank #(.NUM_MOD(NUM_MOD), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_gen  (evt_gen),
        .evt_rx   (evt_rx),
        .evt_tx   (evt_tx),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .flg_o    (flg_w),
        .en_o     (en_w),
        .prio_o   (prio_w),
        .req_live (req_live)
    );

    ipc_arbiter #(.NUM_MOD(NUM_MOD), .VW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_live  (req_live),
        .prio      (prio_w),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_prio  (win_prio)
    );

    assign irq_req   = win_valid && (win_prio > cur_level);
    assign irq_vec   = win_vec;
    assign irq_level = win_prio;
    assign take      = cpu_ack && irq_req;

    ipc_level_stack u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_lvl  (win_prio),
        .pop       (cpu_eoi),
        .cur_level (cur_level)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_MOD; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = {prio_w[i], en_w[i], flg_w[i]};
        end
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_ctrl_pkg::*;
#(
    parameter int NUM_MOD = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic                          cpu_ack,
    input logic                          cpu_eoi,
    input logic                          irq_req,
    input logic [PRIO_W-1:0]             irq_level,
    input logic [PRIO_W-1:0]             cur_level,
    input logic [NUM_MOD-1:0][SRC_N-1:0] flags,
    input logic [NUM_MOD-1:0][SRC_N-1:0] evts
);

    // R1 R3
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evts) |=> ((flags & $past(evts)) == $past(evts)));

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R4
    req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != '0));

    // R8
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_req && !cpu_eoi) |=> (cur_level == $past(irq_level)));

    // R10
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eoi && !cpu_ack && (cur_level != '0)) |=> (cur_level < $past(cur_level)));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_MOD(NUM_MOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .cpu_ack   (cpu_ack),
    .cpu_eoi   (cpu_eoi),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .cur_level (cur_level),
    .flags     (flg_w),
    .evts      (evt_all)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

    localparam int N  = 4;
    localparam int AW = 2;
    localparam int ROWS = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_gen = '0, evt_rx = '0, evt_tx = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [8:0]    reg_wdata = '0;
    logic [8:0]    reg_rdata;
    logic          cpu_ack = 1'b0, cpu_eoi = 1'b0;
    logic          irq_req;
    logic [AW-1:0] irq_vec;
    logic [2:0]    irq_level, cur_level;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_MOD(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .evt_gen(evt_gen), .evt_rx(evt_rx), .evt_tx(evt_tx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_level(irq_level), .cur_level(cur_level)
    );

    // {prio m3..m0, enables m3..m0, events m3..m0, expected valid, expected vector}
    localparam logic [38:0] TBL [ROWS] = '{
        {12'h6DB, 12'hFFF, 12'h040, 1'b1, 2'd2},  // R5 single source
        {12'hAA9, 12'hFFF, 12'h492, 1'b1, 2'd1},  // R6 tie in group 5
        {12'h6DB, 12'hFF8, 12'h004, 1'b0, 2'd0},  // R4 disabled source
        {12'h248, 12'hFFF, 12'h801, 1'b1, 2'd3},  // R4 group 0 ignored
        {12'hDF6, 12'hF3F, 12'h048, 1'b1, 2'd1},  // R4 partial enable
        {12'hDF6, 12'hFFF, 12'h048, 1'b1, 2'd2},  // R5 higher group wins
        {12'h000, 12'hFFF, 12'hFFF, 1'b0, 2'd0}   // R4 all group 0
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int m, input logic [2:0] p, input logic [2:0] e, input logic [2:0] c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(m); reg_wdata = {p, e, c};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] ev);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            evt_gen[i] = ev[3*i]; evt_rx[i] = ev[3*i+1]; evt_tx[i] = ev[3*i+2];
        end
        @(negedge clk);
        evt_gen = '0; evt_rx = '0; evt_tx = '0;
    endtask

    task automatic rd(input int m, output logic [8:0] v);
        reg_addr = AW'(m);
        #0.5;
        v = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic eoi();
        @(negedge clk); cpu_eoi = 1'b1;
        @(negedge clk); cpu_eoi = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R7 reset irq_req", int'(irq_req), 0);
        chk("R10 reset cur_level", int'(cur_level), 0);
        rd(0, v);
        chk("R12 reset register", int'(v), 0);

        for (int r = 0; r < ROWS; r++) begin
            logic [38:0] row;
            row = TBL[r];
            for (int m = 0; m < N; m++)
                wr(m, row[27+3*m +: 3], row[15+3*m +: 3], 3'b111);
            pulse(row[14:3]);
            @(negedge clk);
            chk($sformatf("R4 R5 R6 row%0d valid", r), int'(irq_req), int'(row[2]));
            if (row[2]) chk($sformatf("R5 R6 row%0d vector", r), int'(irq_vec), int'(row[1:0]));
            if (r == 2) begin
                rd(0, v);
                chk("R1 disabled flag visible", int'(v[2:0]), 3'b100);
            end
            if (r == 6) begin
                rd(3, v);
                chk("R12 readback word", int'(v), 9'b000_111_111);
            end
        end

        // directed: latency and ack
        for (int m = 0; m < N; m++) wr(m, 3'd0, 3'd0, 3'b111);
        wr(0, 3'd2, 3'b111, 3'b000);
        pulse(12'h001);
        chk("R7 no request after one edge", int'(irq_req), 0);
        @(negedge clk);
        chk("R7 request after two edges", int'(irq_req), 1);
        chk("R5 level", int'(irq_level), 2);
        ack();
        chk("R8 cur_level after ack", int'(cur_level), 2);
        chk("R8 request drops after ack", int'(irq_req), 0);
        rd(0, v);
        chk("R2 ack keeps flag", int'(v[2:0]), 3'b001);

        // set and clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {3'd2, 3'b111, 3'b001};
        evt_gen[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_gen = '0;
        rd(0, v);
        chk("R3 set wins over clear", int'(v[2:0]), 3'b001);

        // same group does not preempt, higher does
        wr(1, 3'd2, 3'b111, 3'b000);
        pulse(12'h010);
        @(negedge clk);
        chk("R9 same group held", int'(irq_req), 0);
        wr(2, 3'd4, 3'b111, 3'b000);
        pulse(12'h100);
        @(negedge clk);
        chk("R9 higher group preempts", int'(irq_req), 1);
        chk("R9 preempt vector", int'(irq_vec), 2);
        ack();
        chk("R8 nested level", int'(cur_level), 4);

        // unwind
        wr(2, 3'd4, 3'b111, 3'b111);
        eoi();
        @(negedge clk);
        chk("R10 restored level", int'(cur_level), 2);
        chk("R11 loser waits for release", int'(irq_req), 0);
        wr(0, 3'd2, 3'b111, 3'b111);
        eoi();
        @(negedge clk);
        chk("R10 idle level", int'(cur_level), 0);
        chk("R11 loser offered", int'(irq_req), 1);
        chk("R11 loser vector", int'(irq_vec), 1);

        summary();
        $finish;
    end

endmodule